// File: doc/BRIEF.md
# Reed-Solomon Codec Configuration Loader

This block sits in front of a Reed-Solomon encode/decode datapath and owns its static configuration. While the active-low reset input is held low, the ordinary byte-wide input bus and its active-low input strobe are reused to shift in a fixed sequence of six configuration bytes. The block checks the timing rules around that reset window. It decodes the captured bytes into the numeric fields and control flags that the datapath consumes. Once reset is released, it reports whether the loaded set is complete and legal.

The six bytes always arrive in the same order: erasure multiplier, error threshold, check-byte count, message-byte count, block length, and control byte. Before the first byte can be taken, reset must have been low for two clock edges with both strobes idle. After the last byte, reset must stay low for one more edge. After release, two clock edges with reset high must pass before the datapath may accept its first data byte, and the block signals that moment. To change any field, the whole sequence has to be reloaded under a fresh reset.

Top module: `rs_cfg_loader`

## Requirements
- R1: A configuration byte is accepted only after at least two consecutive rising edges with `rst_n` low and both `in_strobe_n` and `out_strobe_n` high. Either strobe going low before that count is reached is ignored and restarts the count from zero.
- R2: Accepted bytes are captured on rising edges where `rst_n` and `in_strobe_n` are both low, at most one per edge, filling slots 1 to 6 in order. `erase_mult` shows slot 1, `check_cnt` shows slot 3 bits [4:0], `msg_cnt` shows slot 4 and `blk_len` shows slot 5.
- R3: `err_thresh` equals the smaller of slot 2 bits [4:0] and slot 3 bits [4:0].
- R4: The control flags come from slot 6: `no_parity` is bit 1, `corrected` is bit 2, `fwd_order` is bit 3, `raw_mode` is bit 4 and `erase_reject` is bit 5.
- R5: Input strobes seen while reset is still low after six bytes are held change no slot and do not wrap to slot 1.
- R6: If reset rises on the edge right after the sixth byte, with no low edge between, the set is reported as a configuration error.
- R7: `run_ok` is high only while `rst_n` is high, after at least two rising edges with `rst_n` high since the reset window, and only for a legal set.
- R8: A reset window that ends with fewer than six bytes captured yields `cfg_error` high and `cfg_done` low.
- R9: The set is illegal if slot 2 or slot 3 has bits [7:5] other than 100 or a value outside 2 to 20. It is also illegal if slot 6 has bit 0, 6 or 7 set, or if the message count is outside 1 to 253 or the block length is below 3.
- R10: The set is illegal when the block length differs from the message count plus the check-byte count.
- R11: The first rising edge with `rst_n` low after a period with it high clears all six slots and drops `cfg_done`.
- R12: `cfg_done` and `cfg_error` are both low while the reset window lasts. From the first rising edge with `rst_n` high onward, exactly one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset; configuration is loaded while low |
| in_strobe_n | input | 1 | Active-low input byte strobe |
| out_strobe_n | input | 1 | Active-low output acknowledge strobe, must be idle before loading |
| din | input | 8 | Input data byte |
| erase_mult | output | 8 | Erasure multiplier field |
| err_thresh | output | 5 | Effective error threshold, limited to the check-byte count |
| check_cnt | output | 5 | Number of check bytes |
| msg_cnt | output | 8 | Number of message bytes |
| blk_len | output | 8 | Block length in bytes |
| no_parity | output | 1 | Check bytes are withheld from the output |
| corrected | output | 1 | Output corrected data rather than correction vectors |
| fwd_order | output | 1 | Output in forward rather than reverse order |
| raw_mode | output | 1 | Bypass correction |
| erase_reject | output | 1 | Erasure rejection control |
| cfg_done | output | 1 | A complete, legal set is loaded |
| cfg_error | output | 1 | The loaded set is incomplete, mistimed or illegal |
| run_ok | output | 1 | The datapath may accept its first data byte |

## Verification
The hardest cases to reach are the timing boundaries of the reset window. One is a strobe that arrives after only one idle low edge, or an output-acknowledge pulse that silently restarts the idle count. The other is a release that lands on the very edge after the sixth byte. The stimulus gets there by driving every reset-window edge one at a time from a task, so each case puts a stray strobe or an early release on an exact edge. The capture of bytes chosen to be distinct shows whether any ignored byte slipped in or shifted the slots.

// File: rtl/rs_cfg_pkg.sv
`timescale 1ns/1ps
package rs_cfg_pkg;

    localparam int DATA_W   = 8;
    localparam int NUM_REGS = 6;
    localparam int CNT_W    = $clog2(NUM_REGS + 1);

    // slot positions follow the fixed load order
    localparam int IDX_MULT = 0;
    localparam int IDX_THR  = 1;
    localparam int IDX_CHK  = 2;
    localparam int IDX_MSG  = 3;
    localparam int IDX_BLK  = 4;
    localparam int IDX_CTL  = 5;

    localparam int CNT_MIN = 2;
    localparam int CNT_MAX = 20;
    localparam int MSG_MIN = 1;
    localparam int MSG_MAX = 253;
    localparam int BLK_MIN = 3;

    typedef enum logic {
        PH_RUN  = 1'b0,
        PH_LOAD = 1'b1
    } phase_e;

    typedef struct packed {
        logic erase_reject;
        logic raw;
        logic forward;
        logic corrected;
        logic no_parity;
    } ctl_t;

    typedef logic [NUM_REGS-1:0][DATA_W-1:0] bank_t;

    function automatic logic count_byte_ok(input logic [DATA_W-1:0] b);
        return (b[7:5] == 3'b100) &&
               (b[4:0] >= 5'(CNT_MIN)) && (b[4:0] <= 5'(CNT_MAX));
    endfunction

    function automatic logic ctl_byte_ok(input logic [DATA_W-1:0] b);
        return (b[0] == 1'b0) && (b[7:6] == 2'b00);
    endfunction

    function automatic ctl_t ctl_decode(input logic [DATA_W-1:0] b);
        ctl_t c;
        c.no_parity    = b[1];
        c.corrected    = b[2];
        c.forward      = b[3];
        c.raw          = b[4];
        c.erase_reject = b[5];
        return c;
    endfunction

    function automatic logic [4:0] min5(input logic [4:0] a, input logic [4:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/rs_cfg_seq.sv
`timescale 1ns/1ps
module rs_cfg_seq
    import rs_cfg_pkg::*;
#(
    parameter int MIN_PRE  = 2,
    parameter int MIN_TAIL = 1,
    parameter int MIN_HIGH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_strobe_n,
    input  logic             out_strobe_n,
    output phase_e           phase,
    output logic             accept,
    output logic             clr,
    output logic [CNT_W-1:0] byte_cnt,
    output logic             full,
    output logic             tail_ok,
    output logic             high_ok
);

    localparam int PW = $clog2(MIN_PRE + 1);
    localparam int TW = $clog2(MIN_TAIL + 1);
    localparam int HW = $clog2(MIN_HIGH + 1);

    logic [PW-1:0] pre_cnt;
    logic [TW-1:0] tail_cnt;
    logic [HW-1:0] hi_cnt;
    logic          idle;

    assign idle    = in_strobe_n && out_strobe_n;
    assign full    = (byte_cnt == CNT_W'(NUM_REGS));
    assign clr     = !rst_n && (phase != PH_LOAD);
    assign accept  = !rst_n && (phase == PH_LOAD) && !in_strobe_n && !full &&
                     (pre_cnt == PW'(MIN_PRE));
    assign tail_ok = (tail_cnt == TW'(MIN_TAIL));
    assign high_ok = (hi_cnt == HW'(MIN_HIGH));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (phase != PH_LOAD) begin
                // first low edge opens a fresh window
                phase    <= PH_LOAD;
                byte_cnt <= '0;
                pre_cnt  <= idle ? PW'(1) : '0;
                tail_cnt <= '0;
                hi_cnt   <= '0;
            end else begin
                if ((byte_cnt == '0) && (pre_cnt != PW'(MIN_PRE)))
                    pre_cnt <= idle ? pre_cnt + 1'b1 : '0;
                if (accept)
                    byte_cnt <= byte_cnt + 1'b1;
                if (full && !tail_ok)
                    tail_cnt <= tail_cnt + 1'b1;
            end
        end else begin
            phase <= PH_RUN;
            if (!high_ok)
                hi_cnt <= hi_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rs_cfg_regbank.sv
`timescale 1ns/1ps
module rs_cfg_regbank
    import rs_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [CNT_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output bank_t             regs
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (clr)
                regs[g] <= '0;
            else if (wr_en && (wr_idx == CNT_W'(g)))
                regs[g] <= wr_data;
        end
    end

endmodule

// File: rtl/rs_cfg_decode.sv
`timescale 1ns/1ps
module rs_cfg_decode
    import rs_cfg_pkg::*;
(
    input  bank_t             regs,
    input  phase_e            phase,
    input  logic              rst_n,
    input  logic              full,
    input  logic              tail_ok,
    input  logic              high_ok,
    output logic [DATA_W-1:0] erase_mult,
    output logic [4:0]        err_thresh,
    output logic [4:0]        check_cnt,
    output logic [DATA_W-1:0] msg_cnt,
    output logic [DATA_W-1:0] blk_len,
    output ctl_t              ctl,
    output logic              cfg_done,
    output logic              cfg_error,
    output logic              run_ok
);

    logic [DATA_W:0] len_sum;
    logic            fields_ok;
    logic            legal;

    assign erase_mult = regs[IDX_MULT];
    assign check_cnt  = regs[IDX_CHK][4:0];
    assign msg_cnt    = regs[IDX_MSG];
    assign blk_len    = regs[IDX_BLK];
    assign err_thresh = min5(regs[IDX_THR][4:0], regs[IDX_CHK][4:0]);
    assign ctl        = ctl_decode(regs[IDX_CTL]);

    assign len_sum = {1'b0, regs[IDX_MSG]} + (DATA_W+1)'(regs[IDX_CHK][4:0]);

    always_comb begin
        fields_ok = count_byte_ok(regs[IDX_THR]) &&
                    count_byte_ok(regs[IDX_CHK]) &&
                    ctl_byte_ok(regs[IDX_CTL]) &&
                    (regs[IDX_MSG] >= DATA_W'(MSG_MIN)) &&
                    (regs[IDX_MSG] <= DATA_W'(MSG_MAX)) &&
                    (regs[IDX_BLK] >= DATA_W'(BLK_MIN)) &&
                    (len_sum == {1'b0, regs[IDX_BLK]});
        legal     = full && tail_ok && fields_ok;
    end

    assign cfg_done  = (phase == PH_RUN) && legal;
    assign cfg_error = (phase == PH_RUN) && !legal;
    assign run_ok    = rst_n && (phase == PH_RUN) && high_ok && legal;

endmodule

// File: rtl/rs_cfg_loader.sv
`timescale 1ns/1ps
module rs_cfg_loader
    import rs_cfg_pkg::*;
#(
    parameter int MIN_PRE  = 2,
    parameter int MIN_TAIL = 1,
    parameter int MIN_HIGH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_strobe_n,
    input  logic       out_strobe_n,
    input  logic [7:0] din,
    output logic [7:0] erase_mult,
    output logic [4:0] err_thresh,
    output logic [4:0] check_cnt,
    output logic [7:0] msg_cnt,
    output logic [7:0] blk_len,
    output logic       no_parity,
    output logic       corrected,
    output logic       fwd_order,
    output logic       raw_mode,
    output logic       erase_reject,
    output logic       cfg_done,
    output logic       cfg_error,
    output logic       run_ok
);

    phase_e           phase;
    logic             phase_load;
    logic             accept;
    logic             clr;
    logic [CNT_W-1:0] byte_cnt;
    logic             full;
    logic             tail_ok;
    logic             high_ok;
    bank_t            regs;
    ctl_t             ctl;

    assign phase_load = (phase == PH_LOAD);

    rs_cfg_seq #(
        .MIN_PRE (MIN_PRE),
        .MIN_TAIL(MIN_TAIL),
        .MIN_HIGH(MIN_HIGH)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_strobe_n (in_strobe_n),
        .out_strobe_n(out_strobe_n),
        .phase       (phase),
        .accept      (accept),
        .clr         (clr),
        .byte_cnt    (byte_cnt),
        .full        (full),
        .tail_ok     (tail_ok),
        .high_ok     (high_ok)
    );

    rs_cfg_regbank u_bank (
        .clk    (clk),
        .clr    (clr),
        .wr_en  (accept),
        .wr_idx (byte_cnt),
        .wr_data(din),
        .regs   (regs)
    );

    rs_cfg_decode u_dec (
        .regs      (regs),
        .phase     (phase),
        .rst_n     (rst_n),
        .full      (full),
        .tail_ok   (tail_ok),
        .high_ok   (high_ok),
        .erase_mult(erase_mult),
        .err_thresh(err_thresh),
        .check_cnt (check_cnt),
        .msg_cnt   (msg_cnt),
        .blk_len   (blk_len),
        .ctl       (ctl),
        .cfg_done  (cfg_done),
        .cfg_error (cfg_error),
        .run_ok    (run_ok)
    );

    assign no_parity    = ctl.no_parity;
    assign corrected    = ctl.corrected;
    assign fwd_order    = ctl.forward;
    assign raw_mode     = ctl.raw;
    assign erase_reject = ctl.erase_reject;

endmodule

// File: rtl/rs_cfg_loader_chk.sv
`timescale 1ns/1ps
module rs_cfg_loader_chk
    import rs_cfg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_strobe_n,
    input logic             out_strobe_n,
    input logic [CNT_W-1:0] byte_cnt,
    input logic             phase_load,
    input logic [7:0]       erase_mult,
    input logic [4:0]       check_cnt,
    input logic [7:0]       msg_cnt,
    input logic [7:0]       blk_len,
    input logic             cfg_done,
    input logic             run_ok
);

    logic [2:0] warm = 3'd0;
    logic       cold;

    always_ff @(posedge clk)
        if (warm != 3'd4) warm <= warm + 3'd1;

    assign cold = (warm != 3'd4);

    AST_PRELOAD_IDLE: assert property (@(posedge clk) disable iff (cold)
        (byte_cnt == CNT_W'(1) && $past(byte_cnt) == CNT_W'(0)) |->
        ($past(!rst_n, 2) && $past(in_strobe_n, 2) && $past(out_strobe_n, 2) &&
         $past(!rst_n, 3) && $past(in_strobe_n, 3) && $past(out_strobe_n, 3))); // R1

    AST_ONE_BYTE_STEP: assert property (@(posedge clk) disable iff (cold)
        (!rst_n && phase_load) |=>
        (byte_cnt == $past(byte_cnt) || byte_cnt == $past(byte_cnt) + CNT_W'(1))); // R2

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (cold)
        (!rst_n && phase_load && byte_cnt == CNT_W'(NUM_REGS)) |=>
        $stable({erase_mult, check_cnt, msg_cnt, blk_len})); // R5

    AST_RUN_AFTER_HIGH: assert property (@(posedge clk) disable iff (cold)
        run_ok |-> (rst_n && $past(rst_n) && $past(rst_n, 2))); // R7

    AST_RUN_NEEDS_DONE: assert property (@(posedge clk) disable iff (cold)
        run_ok |-> cfg_done); // R7

    AST_ENTRY_CLEARS: assert property (@(posedge clk) disable iff (cold)
        ($past(!rst_n) && $past(rst_n, 2)) |->
        (erase_mult == 8'd0 && msg_cnt == 8'd0 && blk_len == 8'd0 && !cfg_done)); // R11

endmodule

bind rs_cfg_loader rs_cfg_loader_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_strobe_n (in_strobe_n),
    .out_strobe_n(out_strobe_n),
    .byte_cnt    (byte_cnt),
    .phase_load  (phase_load),
    .erase_mult  (erase_mult),
    .check_cnt   (check_cnt),
    .msg_cnt     (msg_cnt),
    .blk_len     (blk_len),
    .cfg_done    (cfg_done),
    .run_ok      (run_ok)
);

// File: tb/rs_cfg_loader_bench.sv
`timescale 1ns/1ps
module rs_cfg_loader_bench;

    typedef logic [7:0] cfg_t [6];

    typedef struct packed {
        logic [7:0] m;
        logic [4:0] t;
        logic [4:0] c;
        logic [7:0] k;
        logic [7:0] n;
        logic [4:0] f;
        logic       done;
        logic       err;
        logic       run;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       in_strobe_n = 1'b1;
    logic       out_strobe_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] erase_mult, msg_cnt, blk_len;
    logic [4:0] err_thresh, check_cnt;
    logic       no_parity, corrected, fwd_order, raw_mode, erase_reject;
    logic       cfg_done, cfg_error, run_ok;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;

    always #10 clk = ~clk;

    rs_cfg_loader u_rs_cfg_loader (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_strobe_n (in_strobe_n),
        .out_strobe_n(out_strobe_n),
        .din         (din),
        .erase_mult  (erase_mult),
        .err_thresh  (err_thresh),
        .check_cnt   (check_cnt),
        .msg_cnt     (msg_cnt),
        .blk_len     (blk_len),
        .no_parity   (no_parity),
        .corrected   (corrected),
        .fwd_order   (fwd_order),
        .raw_mode    (raw_mode),
        .erase_reject(erase_reject),
        .cfg_done    (cfg_done),
        .cfg_error   (cfg_error),
        .run_ok      (run_ok)
    );

    // expected outputs from the first n bytes of a sequence (rest read as zero)
    function automatic exp_t mk(input cfg_t b, input int n, input logic d,
                                input logic e, input logic r);
        exp_t x;
        logic [7:0] v [6];
        for (int i = 0; i < 6; i++) v[i] = (i < n) ? b[i] : 8'h00;
        x.m    = v[0];
        x.t    = (v[1][4:0] < v[2][4:0]) ? v[1][4:0] : v[2][4:0];
        x.c    = v[2][4:0];
        x.k    = v[3];
        x.n    = v[4];
        x.f    = {v[5][5], v[5][4], v[5][3], v[5][2], v[5][1]};
        x.done = d;
        x.err  = e;
        x.run  = r;
        return x;
    endfunction

    task automatic drive(input logic r, input logic is, input logic os, input logic [7:0] d);
        @(negedge clk);
        rst_n        = r;
        in_strobe_n  = is;
        out_strobe_n = os;
        din          = d;
    endtask

    // expectation for the state right after the coming rising edge
    task automatic expect_next(input string tag, input exp_t e);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic enter();
        drive(1'b0, 1'b1, 1'b1, 8'h00);
        drive(1'b0, 1'b1, 1'b1, 8'h00);
    endtask

    task automatic load(input cfg_t b, input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            drive(1'b0, 1'b0, 1'b1, b[i]);
            if (gaps) drive(1'b0, 1'b1, 1'b1, 8'h00);
        end
    endtask

    task automatic release_chk(input cfg_t b, input int n, input logic ok, input string tag);
        drive(1'b1, 1'b1, 1'b1, 8'h00);
        expect_next({tag, " / R12 first high edge"}, mk(b, n, ok, !ok, 1'b0));
        drive(1'b1, 1'b1, 1'b1, 8'h00);
        expect_next({tag, " / R7 second high edge"}, mk(b, n, ok, !ok, ok));
        drive(1'b1, 1'b1, 1'b1, 8'h00);
    endtask

    // monitor: compares one queued expectation per rising edge
    initial begin
        exp_t  e;
        exp_t  a;
        string t;
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {erase_mult, err_thresh, check_cnt, msg_cnt, blk_len,
                     erase_reject, raw_mode, fwd_order, corrected, no_parity,
                     cfg_done, cfg_error, run_ok};
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", t, a, e);
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cfg_t zero, c1, c2, c3, c6, c7, c7b, c9;
        zero = '{default: 8'h00};
        c1   = '{8'h5A, 8'h90, 8'h90, 8'd100, 8'd116, 8'h0E};
        c2   = '{8'hC3, 8'h94, 8'h88, 8'd50,  8'd58,  8'h34};
        c3   = '{8'h11, 8'h82, 8'h82, 8'd1,   8'd3,   8'h00};
        c6   = c1; c6[4]  = 8'd117;
        c7   = c1; c7[1]  = 8'h10;
        c7b  = c1; c7b[5] = 8'h0F;
        c9   = '{8'h00, 8'h81, 8'h81, 8'd10,  8'd11,  8'h00};

        repeat (2) @(negedge clk);

        // R12 R11: idle reset window, nothing loaded
        enter();
        expect_next("R12 outputs idle during reset window", mk(zero, 0, 0, 0, 0));
        load(c1, 6, 0);
        expect_next("R2 six bytes captured in order", mk(c1, 6, 0, 0, 0));
        drive(1'b0, 1'b1, 1'b1, 8'h00);
        release_chk(c1, 6, 1'b1, "R4 R7 legal set with flags");

        // R11: re-entry clears
        drive(1'b0, 1'b1, 1'b1, 8'h00);
        expect_next("R11 re-entering reset clears slots", mk(zero, 0, 0, 0, 0));
        drive(1'b0, 1'b1, 1'b1, 8'h00);

        // R3 R5: gapped load, threshold clamp, extra strobes
        load(c2, 6, 1);
        drive(1'b0, 1'b0, 1'b1, 8'hEE);
        drive(1'b0, 1'b0, 1'b1, 8'hEF);
        expect_next("R5 strobes after six bytes ignored", mk(c2, 6, 0, 0, 0));
        release_chk(c2, 6, 1'b1, "R3 threshold limited to check count");

        // R1: strobes before two idle low edges
        drive(1'b0, 1'b1, 1'b1, 8'h00);
        drive(1'b0, 1'b0, 1'b1, 8'h77);
        expect_next("R1 strobe after one idle edge ignored", mk(zero, 0, 0, 0, 0));
        drive(1'b0, 1'b1, 1'b1, 8'h00);
        drive(1'b0, 1'b1, 1'b0, 8'h00);
        drive(1'b0, 1'b1, 1'b1, 8'h00);
        drive(1'b0, 1'b0, 1'b1, 8'h66);
        expect_next("R1 output strobe restarts idle count", mk(zero, 0, 0, 0, 0));
        enter();
        load(c3, 6, 0);
        drive(1'b0, 1'b1, 1'b1, 8'h00);
        release_chk(c3, 6, 1'b1, "R1 R9 minimum legal block after retry");

        // R8: incomplete load
        enter();
        load(c1, 4, 0);
        drive(1'b0, 1'b1, 1'b1, 8'h00);
        release_chk(c1, 4, 1'b0, "R8 only four bytes loaded");

        // R10: length mismatch
        enter();
        load(c6, 6, 0);
        drive(1'b0, 1'b1, 1'b1, 8'h00);
        release_chk(c6, 6, 1'b0, "R10 block length mismatch");

        // R9: reserved bits
        enter();
        load(c7, 6, 0);
        drive(1'b0, 1'b1, 1'b1, 8'h00);
        release_chk(c7, 6, 1'b0, "R9 threshold bit 7 clear");
        enter();
        load(c7b, 6, 0);
        drive(1'b0, 1'b1, 1'b1, 8'h00);
        release_chk(c7b, 6, 1'b0, "R9 control bit 0 set");

        // R6: release with no hold edge
        enter();
        load(c1, 6, 0);
        release_chk(c1, 6, 1'b0, "R6 release right after sixth byte");

        // R9: check count below range
        enter();
        load(c9, 6, 0);
        drive(1'b0, 1'b1, 1'b1, 8'h00);
        release_chk(c9, 6, 1'b0, "R9 check count below minimum");

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule